// File: doc/BRIEF.md
# Receive Packet Deframer with Dual-Seed CRC Check

This block sits behind a despreading front end. It turns a stream of symbol events and decoded bytes into framed packets. A symbol strobe carries two flags: whether the symbol correlated, and whether it matched the start marker. A separate strobe carries each decoded data byte. The block finds where a packet starts and where it ends. It stores the payload in a small receive buffer and checks the trailing CRC16 against two seeds at once.

End of packet is found in one of two ways. In length mode, the first body byte gives the payload size. In silence mode, the block waits for a configurable run of symbols that fail to correlate. A two-bit rate input forces the settings that some rates need. When the packet ends, the status stays frozen until the host pulses an acknowledge. The host reads the buffer through a combinational read port.

Top module: `rx_deframer`

## Requirements
- R1: Start detection with framing on. Two consecutive symbol strobes that both have `sym_sop` set open a packet body. If the second strobe after a marker lacks `sym_sop`, the search starts over.
- R2: Start detection with framing off. Two consecutive symbol strobes that both have `sym_corr` set open a packet body. `sym_sop` is not looked at in this case.
- R3: Effective configuration from `cfg_rate`:
  - Rates 0 and 1 always use framing and length mode, whatever `cfg_framing` and `cfg_len_mode` say.
  - Rate 3 never uses framing.
  - Rate 2 takes framing from `cfg_framing`, and takes length mode only when framing is on and `cfg_len_mode` is 1.
- R4: In length mode, the first body byte is the payload length L. `rx_done` rises on the clock edge that takes byte number 1+L, or byte number 3+L when CRC is on. `rx_len` then reads L. Symbols that fail to correlate never end a length-mode packet.
- R5: In silence mode, `rx_done` rises on the edge that takes the N-th consecutive non-correlating symbol, where N is `cfg_quiet_syms`; a value of 0 acts as 1. A correlating symbol resets the run. `rx_len` reads the number of body bytes, less the 2 CRC bytes when CRC is on.
- R6: How the CRC is computed and compared:
  - The CRC is computed LSB-first with the reflected polynomial 0xA001 (x^16+x^15+x^2+1).
  - It covers the length byte (in length mode) and every payload byte.
  - It is compared with the last two body bytes, read low byte first.
- R7: `crc_ok_seed` is 1 when the received CRC matches the value computed from `cfg_seed`, which is sampled at the start of the packet. `crc_ok_zero` is 1 when it matches the value computed from a zero seed. Both flags are 0 whenever CRC is off.
- R8: Payload byte k (counting from 0, with the length byte excluded) appears on `rd_data` when `rd_addr` is k.
- R9: When a packet has more than DEPTH payload bytes, only the first DEPTH are stored and `rx_ovf` reads 1 at completion. The end of the packet is still found by the normal rule.
- R10: Status and the acknowledge:
  - After reset, `rx_done` is 0.
  - While `rx_done` is 1, `rx_len`, the CRC flags and the buffer hold their values, and new symbols or bytes change nothing.
  - A `host_ack` pulse while done clears `rx_done` and rearms start detection.
  - A `host_ack` at any other time is ignored.
- R11: Byte strobes are ignored until a packet body has been opened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rate | input | 2 | Rate class: 0 unspread, 1 eight bits per symbol, 2 two bits per symbol, 3 one bit per symbol |
| cfg_framing | input | 1 | Request start-marker framing |
| cfg_len_mode | input | 1 | Request length-field end detection |
| cfg_crc_en | input | 1 | Packet carries a trailing CRC16 |
| cfg_seed | input | 16 | Configured CRC start value |
| cfg_quiet_syms | input | THW | Run of missed correlations that ends a packet in silence mode |
| sym_valid | input | 1 | Symbol strobe |
| sym_corr | input | 1 | Symbol correlated |
| sym_sop | input | 1 | Symbol matched the start marker |
| byte_valid | input | 1 | Decoded byte strobe |
| byte_data | input | 8 | Decoded byte |
| host_ack | input | 1 | Host acknowledge; releases the status and rearms |
| rd_addr | input | $clog2(DEPTH) | Buffer read index |
| rd_data | output | 8 | Buffer byte at rd_addr |
| rx_done | output | 1 | Packet complete |
| crc_ok_seed | output | 1 | CRC matches the configured seed |
| crc_ok_zero | output | 1 | CRC matches a zero seed |
| rx_ovf | output | 1 | Payload exceeded the buffer |
| rx_len | output | 8 | Payload length of the finished packet |

## Verification
The assertions assume three things about the inputs:
- `host_ack` is a pulse that the host raises only after it sees `rx_done`.
- The configuration inputs stay stable for the whole of a packet.
- A length-mode packet really delivers the number of bytes its length byte announces.

The stimulus drives one strobe per cycle, either a symbol or a byte. It changes the configuration only while the block is idle or done. It builds every length-mode packet from its own payload list, so the byte count always agrees with the length field.

// File: rtl/rx_deframer.sv
module rx_deframer #(
  parameter int DEPTH = 16,
  parameter int THW   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               cfg_rate,
  input  logic                     cfg_framing,
  input  logic                     cfg_len_mode,
  input  logic                     cfg_crc_en,
  input  logic [15:0]              cfg_seed,
  input  logic [THW-1:0]           cfg_quiet_syms,
  input  logic                     sym_valid,
  input  logic                     sym_corr,
  input  logic                     sym_sop,
  input  logic                     byte_valid,
  input  logic [7:0]               byte_data,
  input  logic                     host_ack,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [7:0]               rd_data,
  output logic                     rx_done,
  output logic                     crc_ok_seed,
  output logic                     crc_ok_zero,
  output logic                     rx_ovf,
  output logic [7:0]               rx_len
);
  localparam int          AW   = $clog2(DEPTH);
  localparam logic [15:0] POLY = 16'hA001;

  typedef enum logic [1:0] {HUNT, ARM, BODY, DONE} st_t;

  st_t         st;
  logic        lm, ce, ovf;
  logic [7:0]  len_f, ccnt, win0, win1;
  logic [8:0]  arr;
  logic [1:0]  wfill;
  logic [15:0] crc_s, crc_z;
  logic [THW-1:0] quiet;
  logic [7:0]  mem [DEPTH];

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ b[i]) ? ((r >> 1) ^ POLY) : (r >> 1);
    return r;
  endfunction

  wire fast      = ~cfg_rate[1];
  wire eff_frame = fast | (cfg_rate == 2'd2 && cfg_framing);
  wire eff_len   = fast | (eff_frame & cfg_len_mode);
  wire hit       = eff_frame ? sym_sop : sym_corr;

  wire       take   = (st == BODY) && byte_valid;
  wire       cons_v = take && (!ce || wfill == 2'd2);
  wire [7:0] cons_b = ce ? win1 : byte_data;
  wire       is_lenb = lm && ccnt == 8'd0;
  wire [7:0] pidx   = ccnt - {7'd0, lm};
  wire       wr     = cons_v && !is_lenb && int'(pidx) < DEPTH;

  wire [7:0] lenv    = (arr == 9'd0) ? byte_data : len_f;
  wire [8:0] tot     = 9'd1 + {1'b0, lenv} + (ce ? 9'd2 : 9'd0);
  wire       len_end = take && lm && (arr + 9'd1 == tot);

  wire [THW:0] q1     = {1'b0, quiet} + (THW+1)'(1);
  wire         sil_end = (st == BODY) && !lm && sym_valid && !sym_corr &&
                         q1 >= {1'b0, cfg_quiet_syms};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= HUNT; lm <= 1'b0; ce <= 1'b0; ovf <= 1'b0;
      len_f <= '0; ccnt <= '0; win0 <= '0; win1 <= '0;
      arr <= '0; wfill <= '0; crc_s <= '0; crc_z <= '0; quiet <= '0;
    end else begin
      case (st)
        HUNT: if (sym_valid && hit) begin
          st <= ARM; lm <= eff_len; ce <= cfg_crc_en; ovf <= 1'b0;
          len_f <= '0; ccnt <= '0; arr <= '0; wfill <= '0;
          crc_s <= cfg_seed; crc_z <= '0; quiet <= '0;
        end
        ARM: if (sym_valid) st <= hit ? BODY : HUNT;
        BODY: begin
          if (take) begin
            arr <= arr + 9'd1;
            if (lm && arr == 9'd0) len_f <= byte_data;
            if (ce) begin
              win0 <= byte_data;
              win1 <= win0;
              if (wfill != 2'd2) wfill <= wfill + 2'd1;
            end
          end
          if (cons_v) begin
            crc_s <= crc_byte(crc_s, cons_b);
            crc_z <= crc_byte(crc_z, cons_b);
            if (ccnt != 8'hFF) ccnt <= ccnt + 8'd1;
            if (!is_lenb && !wr) ovf <= 1'b1;
          end
          if (sym_valid && !lm) quiet <= sym_corr ? '0 : q1[THW-1:0];
          if (len_end || sil_end) st <= DONE;
        end
        DONE: if (host_ack) st <= HUNT;
        default: st <= HUNT;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (wr) mem[pidx[AW-1:0]] <= cons_b;

  wire [15:0] rx_crc = {win0, win1};
  wire        chk_ok = rx_done && ce && wfill == 2'd2;

  assign rd_data     = mem[rd_addr];
  assign rx_done     = (st == DONE);
  assign crc_ok_seed = chk_ok && crc_s == rx_crc;
  assign crc_ok_zero = chk_ok && crc_z == rx_crc;
  assign rx_ovf      = rx_done && ovf;
  assign rx_len      = rx_done ? (lm ? len_f : ccnt) : 8'd0;

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !host_ack |=> rx_done && $stable(rx_len) && $stable(crc_ok_seed) && $stable(crc_ok_zero)); // R10
  AST_ACK_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && host_ack |=> !rx_done); // R10
  AST_CRC_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_ok_seed || crc_ok_zero) |-> rx_done && ce); // R7
  AST_OVF_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf |-> int'(rx_len) > DEPTH); // R9
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> $past(byte_valid || sym_valid)); // R4
endmodule

// File: tb/sim_rx_deframer.sv
module sim_rx_deframer;
  localparam logic [15:0] SEED = 16'h1D0F;

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_rate = 2'd2;
  logic cfg_framing = 1, cfg_len_mode = 1, cfg_crc_en = 1;
  logic [15:0] cfg_seed = SEED;
  logic [3:0] cfg_quiet_syms = 4'd3;
  logic sym_valid = 0, sym_corr = 0, sym_sop = 0, byte_valid = 0, host_ack = 0;
  logic [7:0] byte_data = 0;
  logic [3:0] rd_addr = 0;
  logic [7:0] rd_data, rx_len;
  logic rx_done, crc_ok_seed, crc_ok_zero, rx_ovf;

  int n_cmp = 0, n_bad = 0;
  bit exp_done = 0, mon_on = 0;

  always #2.5 clk = ~clk;

  rx_deframer u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (mon_on) chk("R10 rx_done per cycle", int'(rx_done), int'(exp_done));

  function automatic logic [15:0] crc16(input logic [15:0] s, input logic [7:0] q[$]);
    logic [15:0] c = s;
    foreach (q[k]) for (int i = 0; i < 8; i++) begin
      bit fb = c[0] ^ q[k][i];
      c = c >> 1;
      if (fb) c = c ^ 16'hA001;
    end
    return c;
  endfunction

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic sym(input bit c, input bit s);
    sym_valid = 1; sym_corr = c; sym_sop = s; tick();
    sym_valid = 0; sym_corr = 0; sym_sop = 0;
  endtask
  task automatic byt(input logic [7:0] b);
    byte_valid = 1; byte_data = b; tick(); byte_valid = 0;
  endtask
  task automatic ack(); host_ack = 1; tick(); host_ack = 0; exp_done = 0; endtask

  task automatic verify(input int ln, input bit s, input bit z, input bit o,
                        input logic [7:0] pl[$], input string tag);
    chk({tag, " R4/R5 rx_len"}, int'(rx_len), ln);
    chk({tag, " R7 crc_ok_seed"}, int'(crc_ok_seed), int'(s));
    chk({tag, " R7 crc_ok_zero"}, int'(crc_ok_zero), int'(z));
    chk({tag, " R9 rx_ovf"}, int'(rx_ovf), int'(o));
    foreach (pl[k]) if (k < 16) begin
      rd_addr = 4'(k); #0.2;
      chk({tag, " R8 buffer byte"}, int'(rd_data), int'(pl[k]));
    end
  endtask

  task automatic send_len(input logic [7:0] pl[$], input bit crc_on, input bit zseed,
                          input bit corrupt, input int gaps, input string tag);
    logic [7:0] f[$], tx[$];
    logic [15:0] c, cs, cz;
    f.push_back(8'(pl.size()));
    foreach (pl[k]) f.push_back(pl[k]);
    cs = crc16(SEED, f); cz = crc16(16'h0, f);
    c = zseed ? cz : cs;
    if (corrupt) c = c ^ 16'h0100;
    tx = f;
    if (crc_on) begin tx.push_back(c[7:0]); tx.push_back(c[15:8]); end
    sym(1, 1); sym(1, 1);
    foreach (tx[i]) begin
      byt(tx[i]);
      if (i == 2) repeat (gaps) sym(0, 0);
      if (i == tx.size() - 1) exp_done = 1;
    end
    verify(pl.size(), crc_on && c == cs, crc_on && c == cz, pl.size() > 16, pl, tag);
    ack();
  endtask

  task automatic send_sil(input logic [7:0] pl[$], input string tag);
    logic [7:0] tx[$];
    logic [15:0] c;
    c = crc16(SEED, pl);
    tx = pl; tx.push_back(c[7:0]); tx.push_back(c[15:8]);
    sym(1, 0); sym(1, 0);
    foreach (tx[i]) begin byt(tx[i]); sym(1, 0); end
    sym(0, 0); sym(0, 0); sym(1, 0);
    sym(0, 0); sym(0, 0); sym(0, 0); exp_done = 1;
    verify(pl.size(), 1, 0, 0, pl, tag);
    ack();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] big[$];
    repeat (3) tick();
    rst_n = 1; tick();
    chk("R10 reset rx_done", int'(rx_done), 0);
    mon_on = 1;

    send_len('{8'h11, 8'h22, 8'h33, 8'h44, 8'h55}, 1, 0, 0, 0, "T seed R6");
    send_len('{8'hA5, 8'h5A, 8'h00}, 1, 1, 0, 0, "T zero R7");
    send_len('{8'h01, 8'h02}, 1, 0, 1, 0, "T corrupt R7");
    cfg_crc_en = 0;
    send_len('{}, 0, 0, 0, 0, "T empty R4");
    cfg_crc_en = 1;
    for (int i = 0; i < 20; i++) big.push_back(8'(i * 7 + 3));
    send_len(big, 1, 0, 0, 0, "T overflow R9");

    sym(1, 1); sym(1, 0);
    byt(8'h02); byt(8'h77); byt(8'h88); byt(8'h00); byt(8'h00);
    chk("R1 false start no done", int'(rx_done), 0);
    chk("R11 bytes ignored", int'(rx_done), 0);

    sym(1, 1); ack(); sym(1, 1);
    byt(8'h01); byt(8'h99);
    begin
      logic [15:0] c = crc16(SEED, '{8'h01, 8'h99});
      byt(c[7:0]); byt(c[15:8]); exp_done = 1;
    end
    byt(8'hEE); sym(0, 0); byt(8'hEE);
    verify(1, 1, 0, 0, '{8'h99}, "T ack ignored/hold R10");
    ack();

    cfg_rate = 2'd0; cfg_framing = 0; cfg_len_mode = 0;
    send_len('{8'h10, 8'h20, 8'h30, 8'h40}, 1, 0, 0, 4, "T rate0 forced R3");

    cfg_rate = 2'd2; cfg_framing = 0;
    send_sil('{8'hC1, 8'hC2, 8'hC3}, "T silence R5 R2");

    cfg_rate = 2'd3; cfg_framing = 1; cfg_len_mode = 1;
    sym(0, 1); sym(0, 1);
    chk("R3 rate3 ignores marker", int'(rx_done), 0);
    send_sil('{8'h5C}, "T rate3 R3");

    mon_on = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule